// File: doc/BRIEF.md
# Processor Address Segment Classifier

This block sits beside the address path of a processor core. For each request it decodes the address together with the current privilege level and the address-width mode. It reports which segment of the address space the request falls into. It also tells the rest of the pipeline three things: whether the address must be translated, whether the access may be cached, and which cache algorithm to apply. For unmapped windows it produces the physical address. It flags an address error when the current privilege forbids the access, or when the address carries an illegal field encoding.

The block does not look anything up and does not handle exceptions. It produces a registered classification one cycle after each request, and consumers such as a translation unit, a cache front end or a trap sequencer act on it. The interface is a plain valid strobe with no back-pressure. Every request pulse yields exactly one result pulse one cycle later, so the consumer must accept a result in every cycle. The result fields hold their values until the next request.

Top module: `addr_seg_classifier`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise; classification fields change only on a request.
- R2: In 32-bit mode (`in_wide`=0), an address with bit 31 = 0 is segment code 0 (user, mapped), and bits 31:30 = 11 give segment code 2 (kernel, mapped). Mapped results carry cached=0, algo=000 and paddr=0.
- R3: In 32-bit mode, bits 31:29 = 100 give segment code 3 with cached=1 and algo=110, and bits 31:29 = 101 give segment code 4 with cached=0 and algo=010. Both are unmapped, and paddr is bits 28:0 zero-extended.
- R4: In 32-bit mode, input bits 63:32 have no effect, and `out_vaddr` is bits 31:0 sign-extended from bit 31. In 64-bit mode, `out_vaddr` equals the input address.
- R5: In 64-bit mode, bits 63:62 select the segment: 00 gives code 0 (user, mapped), 01 gives code 1 (supervisor, mapped), 11 gives code 2 (kernel, mapped) and 10 gives code 5 (physical window, unmapped).
- R6: For 64-bit codes 0 and 1, bits 61:44 must be zero. For code 2, either bits 61:44 are zero or bits 61:31 are all ones. Any other value raises the error.
- R7: In the 64-bit physical window, paddr is bits 39:0 and algo is bits 61:59. cached=1 exactly for algo 011, 100, 101 and 110. Algo 000 and 001 are errors.
- R8: In the 64-bit physical window, bits 56:40 must be zero. Bits 58:57 must be 00 unless algo is 010 or 111. A violation raises the error.
- R9: Privilege codes are 00 user, 01 supervisor, 10 kernel and 11 reserved. Segment 0 is allowed for user and kernel, segment 1 for supervisor and kernel, and all others for kernel only. Privilege 11 is always an error.
- R10: When `out_err` is 1, `out_mapped`, `out_cached`, `out_algo` and `out_paddr` are all 0. `out_seg` and `out_vaddr` still report the decode.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| in_addr | input | ADDR_W (64) | Address to classify |
| in_priv | input | 2 | Privilege: 00 user, 01 supervisor, 10 kernel, 11 reserved |
| in_wide | input | 1 | 1 = 64-bit address mode, 0 = 32-bit |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_seg | output | 3 | Segment code (0..5) |
| out_mapped | output | 1 | Address must be translated |
| out_cached | output | 1 | Access is cacheable |
| out_algo | output | 3 | Cache algorithm for unmapped windows |
| out_paddr | output | PHYS_W (40) | Physical address for unmapped windows |
| out_err | output | 1 | Address error |
| out_vaddr | output | ADDR_W (64) | Address as a 64-bit value (sign-extended in 32-bit mode) |

## Verification
The checker watches several properties on every cycle. It checks the one-cycle valid timing and the zeroing of the qualifier fields under an error. It checks that translated results never carry a physical address or cache algorithm. It also checks the sign extension of the reported address in 32-bit mode, the error on user access to the upper 32-bit half, and the selection of the supervisor segment. The exact segment, algorithm and physical address for each window need the bench's sweeps to show them. The same holds for the interplay of the reserved-field rules with each algorithm value, the kernel compatibility range, and the privilege matrix across all four privilege codes.

// File: rtl/addr_seg_pkg.sv
package addr_seg_pkg;
  typedef enum logic [2:0] {
    SEG_USER  = 3'd0,
    SEG_SUPV  = 3'd1,
    SEG_KERN  = 3'd2,
    SEG_WIN_C = 3'd3,
    SEG_WIN_U = 3'd4,
    SEG_WIN64 = 3'd5
  } seg_e;

  typedef enum logic [1:0] {
    PRV_USER = 2'b00,
    PRV_SUPV = 2'b01,
    PRV_KERN = 2'b10,
    PRV_RSVD = 2'b11
  } priv_e;

  localparam logic [2:0] ALG_NONE    = 3'b000;
  localparam logic [2:0] ALG_UNC     = 3'b010;
  localparam logic [2:0] ALG_UNC_ACC = 3'b111;
  localparam logic [2:0] ALG_CWE     = 3'b110;
endpackage

// File: rtl/seg_dec32.sv
module seg_dec32
  import addr_seg_pkg::*;
#(
  parameter int PHYS_W = 40
) (
  input  logic [31:0]       a,
  output seg_e              seg,
  output logic              mapped,
  output logic              cached,
  output logic [2:0]        algo,
  output logic [PHYS_W-1:0] paddr
);
  localparam int WIN_W = 29;

  always_comb begin
    seg    = SEG_USER;
    mapped = 1'b0;
    cached = 1'b0;
    algo   = ALG_NONE;
    paddr  = '0;
    if (!a[31]) begin
      seg    = SEG_USER;
      mapped = 1'b1;
    end else if (a[30]) begin
      seg    = SEG_KERN;
      mapped = 1'b1;
    end else begin
      paddr = {{(PHYS_W-WIN_W){1'b0}}, a[WIN_W-1:0]};
      if (!a[29]) begin
        seg    = SEG_WIN_C;
        cached = 1'b1;
        algo   = ALG_CWE;
      end else begin
        seg  = SEG_WIN_U;
        algo = ALG_UNC;
      end
    end
  end
endmodule

// File: rtl/seg_dec64.sv
module seg_dec64
  import addr_seg_pkg::*;
#(
  parameter int PHYS_W = 40
) (
  input  logic [63:0]       a,
  output seg_e              seg,
  output logic              mapped,
  output logic              cached,
  output logic [2:0]        algo,
  output logic [PHYS_W-1:0] paddr,
  output logic              fmt_err
);
  localparam int VHI = 44;
  localparam int CMP = 31;

  logic hi_zero;
  logic compat_ones;
  assign hi_zero     = ~|a[61:VHI];
  assign compat_ones = &a[61:CMP];

  always_comb begin
    seg     = SEG_USER;
    mapped  = 1'b0;
    cached  = 1'b0;
    algo    = ALG_NONE;
    paddr   = '0;
    fmt_err = 1'b0;
    case (a[63:62])
      2'b00: begin
        seg     = SEG_USER;
        mapped  = 1'b1;
        fmt_err = !hi_zero;
      end
      2'b01: begin
        seg     = SEG_SUPV;
        mapped  = 1'b1;
        fmt_err = !hi_zero;
      end
      2'b11: begin
        seg     = SEG_KERN;
        mapped  = 1'b1;
        fmt_err = !(hi_zero || compat_ones);
      end
      default: begin
        seg     = SEG_WIN64;
        algo    = a[61:59];
        paddr   = a[PHYS_W-1:0];
        cached  = (a[61:59] >= 3'b011) && (a[61:59] <= 3'b110);
        fmt_err = (|a[56:PHYS_W]) || (a[61:59] < 3'b010) ||
                  ((|a[58:57]) && (a[61:59] != ALG_UNC) && (a[61:59] != ALG_UNC_ACC));
      end
    endcase
  end
endmodule

// File: rtl/seg_access_chk.sv
module seg_access_chk
  import addr_seg_pkg::*;
(
  input  seg_e       seg,
  input  logic [1:0] priv,
  output logic       deny
);
  always_comb begin
    case (seg)
      SEG_USER: deny = !(priv == PRV_USER || priv == PRV_KERN);
      SEG_SUPV: deny = !(priv == PRV_SUPV || priv == PRV_KERN);
      default:  deny = (priv != PRV_KERN);
    endcase
  end
endmodule

// File: rtl/addr_seg_classifier.sv
module addr_seg_classifier
  import addr_seg_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int PHYS_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_priv,
  input  logic              in_wide,
  output logic              out_valid,
  output logic [2:0]        out_seg,
  output logic              out_mapped,
  output logic              out_cached,
  output logic [2:0]        out_algo,
  output logic [PHYS_W-1:0] out_paddr,
  output logic              out_err,
  output logic [ADDR_W-1:0] out_vaddr
);
  localparam int NARROW = 32;

  seg_e              s32, s64, sel_seg;
  logic              m32, m64, c32, c64, fe64, deny;
  logic [2:0]        a32, a64;
  logic [PHYS_W-1:0] p32, p64;
  logic [ADDR_W-1:0] vext;

  seg_dec32 #(.PHYS_W(PHYS_W)) u_d32 (
    .a(in_addr[NARROW-1:0]), .seg(s32), .mapped(m32), .cached(c32),
    .algo(a32), .paddr(p32)
  );

  seg_dec64 #(.PHYS_W(PHYS_W)) u_d64 (
    .a(in_addr), .seg(s64), .mapped(m64), .cached(c64),
    .algo(a64), .paddr(p64), .fmt_err(fe64)
  );

  assign sel_seg = in_wide ? s64 : s32;

  seg_access_chk u_acc (.seg(sel_seg), .priv(in_priv), .deny(deny));

  assign vext = in_wide ? in_addr
                        : {{(ADDR_W-NARROW){in_addr[NARROW-1]}}, in_addr[NARROW-1:0]};

  logic              n_err, n_map, n_cac;
  logic [2:0]        n_alg;
  logic [PHYS_W-1:0] n_pa;

  always_comb begin
    n_err = deny || (in_wide && fe64);
    n_map = in_wide ? m64 : m32;
    n_cac = in_wide ? c64 : c32;
    n_alg = in_wide ? a64 : a32;
    n_pa  = in_wide ? p64 : p32;
    if (n_err) begin
      n_map = 1'b0;
      n_cac = 1'b0;
      n_alg = ALG_NONE;
      n_pa  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_seg    <= '0;
      out_mapped <= 1'b0;
      out_cached <= 1'b0;
      out_algo   <= '0;
      out_paddr  <= '0;
      out_err    <= 1'b0;
      out_vaddr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_seg    <= sel_seg;
        out_mapped <= n_map;
        out_cached <= n_cac;
        out_algo   <= n_alg;
        out_paddr  <= n_pa;
        out_err    <= n_err;
        out_vaddr  <= vext;
      end
    end
  end
endmodule

// File: rtl/addr_seg_classifier_chk.sv
module addr_seg_classifier_chk #(
  parameter int ADDR_W = 64,
  parameter int PHYS_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic [1:0]        in_priv,
  input logic              in_wide,
  input logic              out_valid,
  input logic [2:0]        out_seg,
  input logic              out_mapped,
  input logic              out_cached,
  input logic [2:0]        out_algo,
  input logic [PHYS_W-1:0] out_paddr,
  input logic              out_err,
  input logic [ADDR_W-1:0] out_vaddr
);
  // R1
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  // R10
  err_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (!out_mapped && !out_cached && out_algo == 3'd0 && out_paddr == '0));
  // R2
  mapped_no_phys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_mapped |-> (!out_cached && out_algo == 3'd0 && out_paddr == '0));
  // R4
  narrow_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wide) |=> (out_vaddr[ADDR_W-1:32] == {(ADDR_W-32){out_vaddr[31]}}));
  // R9
  user_upper_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wide && in_priv == 2'b00 && in_addr[31]) |=> out_err);
  // R5
  supv_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_wide && in_addr[63:62] == 2'b01) |=> out_seg == 3'd1);
endmodule

bind addr_seg_classifier addr_seg_classifier_chk #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
  .in_priv(in_priv), .in_wide(in_wide), .out_valid(out_valid),
  .out_seg(out_seg), .out_mapped(out_mapped), .out_cached(out_cached),
  .out_algo(out_algo), .out_paddr(out_paddr), .out_err(out_err),
  .out_vaddr(out_vaddr)
);

// File: tb/sim_addr_seg_classifier.sv
`timescale 1ns/1ps
module sim_addr_seg_classifier;
  typedef struct packed {
    logic [2:0]  seg;
    logic        m;
    logic        c;
    logic [2:0]  al;
    logic [39:0] pa;
    logic        e;
    logic [63:0] va;
  } res_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [63:0] in_addr = '0;
  logic [1:0] in_priv = '0;
  logic in_wide = 1'b0;
  logic out_valid, out_mapped, out_cached, out_err;
  logic [2:0] out_seg, out_algo;
  logic [39:0] out_paddr;
  logic [63:0] out_vaddr;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  addr_seg_classifier u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_priv(in_priv), .in_wide(in_wide), .out_valid(out_valid),
    .out_seg(out_seg), .out_mapped(out_mapped), .out_cached(out_cached),
    .out_algo(out_algo), .out_paddr(out_paddr), .out_err(out_err),
    .out_vaddr(out_vaddr)
  );

  function automatic res_t model(input logic [63:0] a, input logic [1:0] p, input logic w);
    res_t r;
    logic [2:0] al;
    r = '0;
    r.va = w ? a : {{32{a[31]}}, a[31:0]};
    if (!w) begin
      if (!a[31]) begin r.seg = 0; r.m = 1; end
      else if (a[30]) begin r.seg = 2; r.m = 1; end
      else if (!a[29]) begin r.seg = 3; r.c = 1; r.al = 3'b110; r.pa = {11'd0, a[28:0]}; end
      else begin r.seg = 4; r.al = 3'b010; r.pa = {11'd0, a[28:0]}; end
    end else begin
      case (a[63:62])
        2'b00: begin r.seg = 0; r.m = 1; r.e = (a[61:44] != 0); end
        2'b01: begin r.seg = 1; r.m = 1; r.e = (a[61:44] != 0); end
        2'b11: begin r.seg = 2; r.m = 1; r.e = !((a[61:44] == 0) || (a[61:31] == {31{1'b1}})); end
        default: begin
          al = a[61:59];
          r.seg = 5; r.al = al; r.pa = a[39:0];
          r.c = (al == 3) || (al == 4) || (al == 5) || (al == 6);
          r.e = (a[56:40] != 0) || (al == 0) || (al == 1) ||
                ((a[58:57] != 0) && al != 2 && al != 7);
        end
      endcase
    end
    if (r.seg == 0)      r.e = r.e || !(p == 0 || p == 2);
    else if (r.seg == 1) r.e = r.e || !(p == 1 || p == 2);
    else                 r.e = r.e || (p != 2);
    if (r.e) begin r.m = 0; r.c = 0; r.al = 0; r.pa = 0; end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [63:0] a, input logic [1:0] p, input logic w);
    res_t ex, ac;
    @(negedge clk);
    in_addr = a; in_priv = p; in_wide = w; in_valid = 1'b1;
    ex = model(a, p, w);
    @(negedge clk);
    in_valid = 1'b0;
    ac = '{out_seg, out_mapped, out_cached, out_algo, out_paddr, out_err, out_vaddr};
    check("R1", {127'd0, out_valid}, 128'd1);
    check(ex.e ? "R10" : tag, {16'd0, ac}, {16'd0, ex});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    res_t hold;
    logic [63:0] a;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", {56'd0, out_valid, out_seg, out_mapped, out_cached, out_algo, out_err, out_paddr != 0, out_vaddr != 0},
          128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {127'd0, out_valid}, 128'd0);

    // R2 R3 R9 sweep in 32-bit mode with garbage upper half
    for (int t = 0; t < 8; t++)
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < 2; k++) begin
          a = {$urandom(), 3'(t), 29'($urandom())};
          run((t >= 4 && t <= 5) ? "R3" : "R2", a, 2'(p), 1'b0);
        end

    // R4: upper half ignored, same low half gives same result
    run("R4", 64'h0000_0000_A123_4567, 2'b10, 1'b0);
    hold = '{out_seg, out_mapped, out_cached, out_algo, out_paddr, out_err, out_vaddr};
    run("R4", 64'h5A5A_F00D_A123_4567, 2'b10, 1'b0);
    check("R4", {16'd0, out_seg, out_mapped, out_cached, out_algo, out_paddr, out_err, out_vaddr},
          {16'd0, hold});
    check("R4", out_vaddr, 64'hFFFF_FFFF_A123_4567);

    // R5 segment selection with legal addresses
    run("R5", 64'h0000_0FFF_0000_1000, 2'b00, 1'b1);
    run("R5", 64'h4000_0000_0000_2000, 2'b01, 1'b1);
    run("R5", 64'hC000_0000_0000_3000, 2'b10, 1'b1);
    run("R5", 64'h9000_0012_3456_7890, 2'b10, 1'b1);

    // R6 mapped range checks across privileges
    for (int t = 0; t < 4; t++) begin
      if (t == 2) continue;
      for (int v = 0; v < 5; v++)
        for (int p = 0; p < 4; p++) begin
          case (v)
            0: a = 64'h0000_0ABC_DEF0_1234;
            1: a = 64'h0000_1000_0000_0000;
            2: a = 64'h2000_0000_0000_0000;
            3: a = 64'h3FFF_FFFF_8000_0040;
            default: a = 64'h3FFF_FFFF_7FFF_FFFF;
          endcase
          a[63:62] = 2'(t);
          run(p == 2 ? "R6" : "R9", a, 2'(p), 1'b1);
        end
    end

    // R7 R8 physical window sweep
    for (int al = 0; al < 8; al++)
      for (int f = 0; f < 4; f++)
        for (int h = 0; h < 2; h++) begin
          a = {2'b10, 3'(al), 2'(f), 17'(h ? 17'h00100 : 17'h0), 40'h12_3456_789A};
          run((f != 0 || h != 0) ? "R8" : "R7", a, 2'b10, 1'b1);
        end
    run("R9", 64'h9000_0000_0000_1000, 2'b01, 1'b1);
    run("R9", 64'h4000_0000_0000_1000, 2'b00, 1'b1);
    run("R9", 64'h0000_0000_0000_1000, 2'b01, 1'b1);
    run("R9", 64'h0000_0000_0000_1000, 2'b11, 1'b1);

    // R1: idle cycle keeps valid low and holds fields
    hold = '{out_seg, out_mapped, out_cached, out_algo, out_paddr, out_err, out_vaddr};
    @(negedge clk);
    check("R1", {127'd0, out_valid}, 128'd0);
    check("R1", {16'd0, out_seg, out_mapped, out_cached, out_algo, out_paddr, out_err, out_vaddr},
          {16'd0, hold});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule